// File: doc/BRIEF.md
# Sector Hamming ECC Checker-Corrector

This block judges one 512-byte flash sector after it has been read. It receives two 3-byte Hamming codes: the one kept in the page's spare area and the one recomputed from the sector data during the read. Each code is rearranged into a 32-bit word, and the two words are XORed to form a syndrome. The number of set bits in the syndrome selects the outcome. The sector can be clean, hold one correctable data-bit flip, have a damaged stored code, be a freshly erased page, or hold an error that cannot be corrected.

The surrounding controller pulses `start` while both codes are on the inputs. One cycle later, `done` pulses and the result is on `status`. For a correctable flip, `fix_strobe` pulses together with `done`, and `byte_idx` and `bit_idx` name the data bit that the sector buffer must invert. The result stays on the outputs until the next `start`.

Top module: `hamming_sector_check`

## Requirements
- R1: Code byte k sits on bits [8k+7:8k] of each code input. Before comparison, byte 0 goes to bits 7:0 of a 32-bit word, byte 1 to bits 23:16, the upper nibble of byte 2 to bits 27:24 and its lower nibble to bits 11:8. All other bits are zero.
- R2: When the syndrome is zero, `status` is 2'b00 (good) and `fix_strobe` stays low.
- R3: When the syndrome has exactly 12 set bits, `status` is 2'b01 (fixed) and `fix_strobe` pulses. `bit_idx` is syndrome bits 18:16 and `byte_idx` is syndrome bits 27:19, so the byte range is 0 to 511.
- R4: When the syndrome has exactly 1 set bit, `status` is 2'b10 (stored code damaged) and no correction is requested.
- R5: Any other nonzero weight gives `status` 2'b11 (uncorrectable) with no correction, except for the case in R6.
- R6: A stored code with every byte 0xFF (rearranged 0x0FFF0FFF) together with a computed code of zero is an erased page. It reports 2'b00 with no correction.
- R7: `done` goes high for exactly the one cycle after a cycle in which `start` was high, and all results are valid in that cycle.
- R8: Without `start`, changes on the code inputs have no effect. `status`, `byte_idx` and `bit_idx` hold, and `fix_strobe` and `done` stay low.
- R9: After reset, `status`, `byte_idx`, `bit_idx`, `fix_strobe` and `done` are all zero.
- R10: Whenever the outcome is not 2'b01, `byte_idx` and `bit_idx` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Judge the codes present this cycle |
| stored_code | input | 24 | Code read from the spare area, byte k at [8k+7:8k] |
| calc_code | input | 24 | Code recomputed from the sector data |
| status | output | 2 | 00 good/erased, 01 fixed, 10 code damaged, 11 uncorrectable |
| byte_idx | output | 9 | Byte of the sector to correct |
| bit_idx | output | 3 | Bit within that byte to invert |
| fix_strobe | output | 1 | One-cycle request to invert the named bit |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
Code pairs are applied that give syndromes of weight 0, 1, 2, 12, 13 and 23. This separates every branch of the weight decision. The weight-12 cases include the lowest address (byte 0, bit 0), the highest address (byte 511, bit 7), and a mixed pattern applied both with zero and with nonzero computed codes. Together they show that the result depends only on the XOR and that the nibble placement of byte 2 is correct. A stored all-0xFF code is paired once with a zero computed code and once with a computed code that differs by one bit. The first must be read as an erased page and the second must not.

// File: rtl/hsc_pkg.sv
package hsc_pkg;

  localparam int CODE_W = 24;
  localparam int SYN_W  = 32;
  localparam int WGT_W  = $clog2(SYN_W + 1);

  typedef enum logic [1:0] {
    ST_GOOD     = 2'b00,
    ST_FIXED    = 2'b01,
    ST_CODE_BAD = 2'b10,
    ST_FATAL    = 2'b11
  } hsc_status_e;

  // Rearrange the three code bytes into the comparison word.
  function automatic logic [SYN_W-1:0] spread_code(input logic [CODE_W-1:0] c);
    return {4'h0, c[23:20], c[15:8], 4'h0, c[19:16], c[7:0]};
  endfunction

  // Number of set bits in a syndrome word.
  function automatic logic [WGT_W-1:0] ones_in(input logic [SYN_W-1:0] s);
    logic [WGT_W-1:0] n;
    n = '0;
    for (int i = 0; i < SYN_W; i++) n = n + WGT_W'(s[i]);
    return n;
  endfunction

endpackage

// File: rtl/hsc_spread.sv
module hsc_spread
  import hsc_pkg::*;
(
  input  logic [CODE_W-1:0] code_in,
  output logic [SYN_W-1:0]  word_out
);
  assign word_out = spread_code(code_in);
endmodule

// File: rtl/hsc_judge.sv
module hsc_judge
  import hsc_pkg::*;
#(
  parameter int              FIX_WEIGHT  = 12,
  parameter logic [31:0]     ERASED_WORD = 32'h0FFF0FFF,
  parameter int              BYTE_W      = 9,
  parameter int              BIT_W       = 3
) (
  input  logic [SYN_W-1:0]  stored_w,
  input  logic [SYN_W-1:0]  calc_w,
  output hsc_status_e       verdict,
  output logic [WGT_W-1:0]  weight,
  output logic [BYTE_W-1:0] byte_sel,
  output logic [BIT_W-1:0]  bit_sel
);
  localparam int ADDR_LSB = SYN_W / 2;

  logic [SYN_W-1:0] syndrome;
  logic             erased_pair;

  assign syndrome    = stored_w ^ calc_w;
  assign weight      = ones_in(syndrome);
  assign erased_pair = (stored_w == ERASED_WORD) && (calc_w == '0);

  always_comb begin
    if (weight == '0)                            verdict = ST_GOOD;
    else if (weight == WGT_W'(FIX_WEIGHT))       verdict = ST_FIXED;
    else if (weight == WGT_W'(1))                verdict = ST_CODE_BAD;
    else if (erased_pair)                        verdict = ST_GOOD;
    else                                         verdict = ST_FATAL;
  end

  assign bit_sel  = syndrome[ADDR_LSB +: BIT_W];
  assign byte_sel = syndrome[ADDR_LSB + BIT_W +: BYTE_W];
endmodule

// File: rtl/hsc_result_reg.sv
module hsc_result_reg
  import hsc_pkg::*;
#(
  parameter int BYTE_W = 9,
  parameter int BIT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  hsc_status_e       verdict,
  input  logic [BYTE_W-1:0] byte_sel,
  input  logic [BIT_W-1:0]  bit_sel,
  output logic [1:0]        status_q,
  output logic [BYTE_W-1:0] byte_q,
  output logic [BIT_W-1:0]  bit_q,
  output logic              fix_q,
  output logic              done_q
);
  logic is_fix;
  assign is_fix = (verdict == ST_FIXED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 2'b00;
      byte_q   <= '0;
      bit_q    <= '0;
      fix_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= take;
      fix_q  <= take && is_fix;
      if (take) begin
        status_q <= verdict;
        byte_q   <= is_fix ? byte_sel : '0;
        bit_q    <= is_fix ? bit_sel  : '0;
      end
    end
  end
endmodule

// File: rtl/hamming_sector_check.sv
module hamming_sector_check
  import hsc_pkg::*;
#(
  parameter int          SECTOR_BYTES = 512,
  parameter int          FIX_WEIGHT   = 12,
  parameter logic [31:0] ERASED_WORD  = 32'h0FFF0FFF
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  input  logic [23:0]                       stored_code,
  input  logic [23:0]                       calc_code,
  output logic [1:0]                        status,
  output logic [$clog2(SECTOR_BYTES)-1:0]   byte_idx,
  output logic [2:0]                        bit_idx,
  output logic                              fix_strobe,
  output logic                              done
);
  localparam int BYTE_W = $clog2(SECTOR_BYTES);
  localparam int BIT_W  = 3;

  logic [SYN_W-1:0]  stored_w;
  logic [SYN_W-1:0]  calc_w;
  hsc_status_e       verdict_w;
  logic [WGT_W-1:0]  weight_w;
  logic [BYTE_W-1:0] byte_w;
  logic [BIT_W-1:0]  bit_w;

  hsc_spread u_spread_stored (.code_in(stored_code), .word_out(stored_w));
  hsc_spread u_spread_calc   (.code_in(calc_code),   .word_out(calc_w));

  hsc_judge #(
    .FIX_WEIGHT (FIX_WEIGHT),
    .ERASED_WORD(ERASED_WORD),
    .BYTE_W     (BYTE_W),
    .BIT_W      (BIT_W)
  ) u_judge (
    .stored_w(stored_w),
    .calc_w  (calc_w),
    .verdict (verdict_w),
    .weight  (weight_w),
    .byte_sel(byte_w),
    .bit_sel (bit_w)
  );

  hsc_result_reg #(
    .BYTE_W(BYTE_W),
    .BIT_W (BIT_W)
  ) u_result (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (start),
    .verdict (verdict_w),
    .byte_sel(byte_w),
    .bit_sel (bit_w),
    .status_q(status),
    .byte_q  (byte_idx),
    .bit_q   (bit_idx),
    .fix_q   (fix_strobe),
    .done_q  (done)
  );
endmodule

// File: rtl/hsc_checker_sva.sv
module hsc_checker_sva #(
  parameter int BYTE_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [1:0]        status,
  input logic [BYTE_W-1:0] byte_idx,
  input logic [2:0]        bit_idx,
  input logic              fix_strobe,
  input logic              done
);
  a_r7_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  a_r8_quiet_without_start: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (!done && !fix_strobe));

  a_r8_hold_without_start: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(status) && $stable(byte_idx) && $stable(bit_idx)));

  a_r3_strobe_matches_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fix_strobe == (status == 2'b01)));

  a_r3_strobe_only_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    fix_strobe |-> done);

  a_r10_no_index_unless_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 2'b01) |-> (byte_idx == '0 && bit_idx == '0));
endmodule

bind hamming_sector_check hsc_checker_sva #(.BYTE_W(BYTE_W)) u_hsc_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .status    (status),
  .byte_idx  (byte_idx),
  .bit_idx   (bit_idx),
  .fix_strobe(fix_strobe),
  .done      (done)
);

// File: tb/hamming_sector_check_bench.sv
module hamming_sector_check_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] stored_code = '0;
  logic [23:0] calc_code = '0;
  logic [1:0]  status;
  logic [8:0]  byte_idx;
  logic [2:0]  bit_idx;
  logic        fix_strobe;
  logic        done;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hamming_sector_check u_hamming_sector_check (
    .clk(clk), .rst_n(rst_n), .start(start),
    .stored_code(stored_code), .calc_code(calc_code),
    .status(status), .byte_idx(byte_idx), .bit_idx(bit_idx),
    .fix_strobe(fix_strobe), .done(done)
  );

  // {stored, calc, expected status, expected byte, expected bit}
  localparam logic [61:0] VEC [NVEC] = '{
    {24'h123456, 24'h123456, 2'd0, 9'd0,   3'd0},
    {24'h0F00FF, 24'h000000, 2'd1, 9'd0,   3'd0},
    {24'hF0FF00, 24'h000000, 2'd1, 9'd511, 3'd7},
    {24'hA5AD52, 24'h000000, 2'd1, 9'd341, 3'd5},
    {24'h99916E, 24'h3C3C3C, 2'd1, 9'd341, 3'd5},
    {24'h000FFF, 24'h000000, 2'd1, 9'd1,   3'd7},
    {24'h000001, 24'h000000, 2'd2, 9'd0,   3'd0},
    {24'h000000, 24'h100000, 2'd2, 9'd0,   3'd0},
    {24'h000003, 24'h000000, 2'd3, 9'd0,   3'd0},
    {24'h001FFF, 24'h000000, 2'd3, 9'd0,   3'd0},
    {24'hFFFFFF, 24'h000001, 2'd3, 9'd0,   3'd0}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [1:0] st);
    case (st)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic apply(input logic [23:0] s, input logic [23:0] c);
    @(negedge clk);
    stored_code = s;
    calc_code   = c;
    start       = 1'b1;
    @(negedge clk);
    start       = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(status == 2'b00, "R9", "status", status, 0);
    check(byte_idx == 0 && bit_idx == 0, "R9", "indices", {byte_idx, bit_idx}, 0);
    check(!fix_strobe && !done, "R9", "pulses", {fix_strobe, done}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] est;
      est = VEC[i][13:12];
      apply(VEC[i][61:38], VEC[i][37:14]);
      check(status == est, tag_of(est), "status", status, est);
      check(byte_idx == VEC[i][11:3], est == 2'd1 ? "R1" : "R10", "byte_idx",
            byte_idx, VEC[i][11:3]);
      check(bit_idx == VEC[i][2:0], est == 2'd1 ? "R3" : "R10", "bit_idx",
            bit_idx, VEC[i][2:0]);
      check(fix_strobe == (est == 2'd1), tag_of(est), "fix_strobe",
            fix_strobe, est == 2'd1);
      check(done, "R7", "done", done, 1);
    end

    // R6 erased page
    apply(24'hFFFFFF, 24'h000000);
    check(status == 2'b00, "R6", "erased status", status, 0);
    check(!fix_strobe, "R6", "erased strobe", fix_strobe, 0);

    // R7 done is a single pulse
    apply(24'hF0FF00, 24'h000000);
    check(done && fix_strobe, "R7", "pulse high", {done, fix_strobe}, 3);
    @(negedge clk);
    check(!done && !fix_strobe, "R7", "pulse low", {done, fix_strobe}, 0);

    // R8 inputs changed without start are ignored
    stored_code = 24'h000003;
    calc_code   = 24'h000000;
    repeat (3) @(negedge clk);
    check(status == 2'b01, "R8", "held status", status, 1);
    check(byte_idx == 9'd511 && bit_idx == 3'd7, "R8", "held indices",
          {byte_idx, bit_idx}, {9'd511, 3'd7});
    check(!done && !fix_strobe, "R8", "no pulses", {done, fix_strobe}, 0);

    // R10 indices cleared after a non-fixed result
    apply(24'h000003, 24'h000000);
    check(byte_idx == 0 && bit_idx == 0, "R10", "cleared indices",
          {byte_idx, bit_idx}, 0);

    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule